// File: doc/BRIEF.md
# Power-Budgeted Write Unit Scheduler

This block decides which of eight 16-bit write units go to the cell write driver in each write cycle. The combined power of each group must stay within a fixed budget. Each unit has a 2-bit class code. Code 00 marks a unit whose content can be rebuilt from the code alone, so that unit is never written. Code 11 marks a full-power unit. Codes 01 and 10 mark half-power units, in which only half of the bits carry data.

A `start` pulse captures the class codes and a mode bit. The scheduler then presents one group at a time as a one-bit-per-unit mask. It holds each group until the driver acknowledges it, and raises `done` for one cycle once every unit that needs writing has been written. Full-power units are issued first and half-power units fill the remaining budget. In the inverted-data mode every unit costs half as much, so more units fit into each cycle.

Top module: `wu_power_sched`

## Requirements
- R1: After reset, `issue_valid`, `issue_mask` and `done` are all 0.
- R2: In the idle state, a `start` pulse captures `prefix_in` and `flip_mode`. Unit i's code sits at bits [2i+1:2i]. Changes to these inputs after the capture do not affect the groups issued.
- R3: A unit with code 00 never appears in `issue_mask`. Every unit with a non-zero code appears in exactly one issued group.
- R4: With `flip_mode`=0, code 11 units are issued alone, one per group, in ascending index order. All of them are issued before any code 01 or 10 unit.
- R5: With `flip_mode`=0, code 01 and 10 units are issued two per group in ascending index order, and an odd last unit is issued alone. For example, codes 16'hF384 take 4 groups.
- R6: With `flip_mode`=1, a code 11 unit costs 8 and a code 01 or 10 unit costs 4, against a budget of 16. Each group is filled greedily: pending code 11 units in ascending order first, then code 01 and 10 units in ascending order, and each unit is added if its cost still fits the remaining budget. For example, 16'hF384 takes 2 groups.
- R7: `issue_mask` and `issue_valid` stay unchanged until `wr_ack` is sampled high. A `wr_ack` while no group is presented has no effect.
- R8: In the cycle after the last group is acknowledged, `done` is 1 for exactly one cycle and no group is presented. After that the block is idle.
- R9: If every captured code is 00, `done` is 1 in the cycle right after the `start` edge and no group is ever presented.
- R10: A `start` pulse while groups are still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures codes and mode when idle |
| flip_mode | input | 1 | 1 selects the halved-cost inverted-data mode |
| prefix_in | input | 16 | Two-bit class code per unit, unit i at [2i+1:2i] |
| wr_ack | input | 1 | Driver has finished the presented group |
| issue_valid | output | 1 | A group is being presented |
| issue_mask | output | 8 | One bit per unit in the presented group |
| done | output | 1 | One-cycle pulse once all units are written |

## Verification
The first group becomes visible in the cycle after the `start` edge, because it passes through one register stage. Each later group, or `done`, becomes visible in the cycle after the edge that samples `wr_ack`. In the all-zero case, `done` appears directly after the `start` edge. The bench drives inputs on falling edges and samples at the next falling edge, after exactly one rising edge. While a group is held, it waits a random number of cycles and re-checks the mask each cycle. It also injects stray `start` pulses and input changes during these waits.

// File: rtl/wus_pkg.sv
package wus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HEAVY = 2'd1,
        ST_LIGHT = 2'd2,
        ST_DONE  = 2'd3
    } wus_state_e;
endpackage

// File: rtl/wus_classify.sv
module wus_classify #(
    parameter int N_UNITS = 8,
    parameter int PFX_W   = 2
) (
    input  logic [N_UNITS*PFX_W-1:0] codes,
    output logic [N_UNITS-1:0]       is_heavy,
    output logic [N_UNITS-1:0]       is_light,
    output logic [N_UNITS-1:0]       is_zero
);
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic [PFX_W-1:0] code;
        assign code        = codes[u*PFX_W +: PFX_W];
        assign is_zero[u]  = (code == '0);
        assign is_heavy[u] = (code == '1);
        assign is_light[u] = !is_zero[u] && !is_heavy[u];
    end
endmodule

// File: rtl/wus_pack.sv
module wus_pack #(
    parameter int N_UNITS    = 8,
    parameter int BUDGET     = 16,
    parameter int COST_HEAVY = 16,
    parameter int COST_LIGHT = 8
) (
    input  logic               flip,
    input  logic [N_UNITS-1:0] heavy,
    input  logic [N_UNITS-1:0] light,
    output logic [N_UNITS-1:0] group
);
    localparam int COST_W = $clog2(BUDGET + 1) + 1;
    localparam logic [COST_W-1:0] LIMIT  = COST_W'(BUDGET);
    localparam logic [COST_W-1:0] CH_NRM = COST_W'(COST_HEAVY);
    localparam logic [COST_W-1:0] CL_NRM = COST_W'(COST_LIGHT);
    localparam logic [COST_W-1:0] CH_FLP = COST_W'(COST_HEAVY / 2);
    localparam logic [COST_W-1:0] CL_FLP = COST_W'(COST_LIGHT / 2);

    logic [COST_W-1:0] cost_h, cost_l;
    assign cost_h = flip ? CH_FLP : CH_NRM;
    assign cost_l = flip ? CL_FLP : CL_NRM;

    // Greedy fill: heavy class ascending, then light class ascending
    always_comb begin
        logic [COST_W-1:0] left;
        left  = LIMIT;
        group = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (heavy[i] && (cost_h <= left)) begin
                group[i] = 1'b1;
                left     = left - cost_h;
            end
        end
        for (int i = 0; i < N_UNITS; i++) begin
            if (light[i] && (cost_l <= left)) begin
                group[i] = 1'b1;
                left     = left - cost_l;
            end
        end
    end
endmodule

// File: rtl/wu_power_sched.sv
module wu_power_sched #(
    parameter int N_UNITS    = 8,
    parameter int PFX_W      = 2,
    parameter int BUDGET     = 16,
    parameter int COST_HEAVY = 16,
    parameter int COST_LIGHT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       flip_mode,
    input  logic [N_UNITS*PFX_W-1:0]   prefix_in,
    input  logic                       wr_ack,
    output logic                       issue_valid,
    output logic [N_UNITS-1:0]         issue_mask,
    output logic                       done
);
    import wus_pkg::*;

    localparam int LIGHT_PER = BUDGET / COST_LIGHT;

    typedef struct packed {
        wus_state_e         st;
        logic               flip;
        logic [N_UNITS-1:0] heavy;
        logic [N_UNITS-1:0] light;
        logic [N_UNITS-1:0] zero;
    } regs_t;

    regs_t q, d;

    logic [N_UNITS-1:0] new_h, new_l, new_z, grp;
    logic [N_UNITS-1:0] rem_h, rem_l;

    wus_classify #(.N_UNITS(N_UNITS), .PFX_W(PFX_W)) u_cls (
        .codes    (prefix_in),
        .is_heavy (new_h),
        .is_light (new_l),
        .is_zero  (new_z)
    );

    wus_pack #(
        .N_UNITS(N_UNITS), .BUDGET(BUDGET),
        .COST_HEAVY(COST_HEAVY), .COST_LIGHT(COST_LIGHT)
    ) u_pack (
        .flip  (q.flip),
        .heavy (q.heavy),
        .light (q.light),
        .group (grp)
    );

    function automatic wus_state_e pick_state(input logic [N_UNITS-1:0] h,
                                              input logic [N_UNITS-1:0] l);
        if (|h)      return ST_HEAVY;
        else if (|l) return ST_LIGHT;
        else         return ST_DONE;
    endfunction

    assign rem_h = q.heavy & ~grp;
    assign rem_l = q.light & ~grp;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.flip  = flip_mode;
                    d.heavy = new_h;
                    d.light = new_l;
                    d.zero  = new_z;
                    d.st    = pick_state(new_h, new_l);
                end
            end
            ST_HEAVY, ST_LIGHT: begin
                if (wr_ack) begin
                    d.heavy = rem_h;
                    d.light = rem_l;
                    d.st    = pick_state(rem_h, rem_l);
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.flip  <= 1'b0;
            q.heavy <= '0;
            q.light <= '0;
            q.zero  <= '0;
        end else begin
            q <= d;
        end
    end

    assign issue_valid = (q.st == ST_HEAVY) || (q.st == ST_LIGHT);
    assign issue_mask  = issue_valid ? grp : '0;
    assign done        = (q.st == ST_DONE);

    // Power drawn by the presented group, summed independently of the packer
    logic [15:0] grp_cost;
    always_comb begin
        grp_cost = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (issue_mask[i]) begin
                if (q.heavy[i]) grp_cost = grp_cost + 16'(q.flip ? COST_HEAVY/2 : COST_HEAVY);
                else            grp_cost = grp_cost + 16'(q.flip ? COST_LIGHT/2 : COST_LIGHT);
            end
        end
    end

    a_r6_budget: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (grp_cost <= 16'(BUDGET) && grp_cost != '0));
    a_r3_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((issue_mask & q.zero) == '0));
    a_r4_heavy_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !q.flip && |(issue_mask & q.heavy)) |-> ($countones(issue_mask) == 1));
    a_r4_heavy_first: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !q.flip && |q.heavy) |-> ((issue_mask & q.light) == '0));
    a_r5_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !q.flip && !(|q.heavy)) |->
        ($countones(issue_mask) == (($countones(q.light) >= LIGHT_PER) ? LIGHT_PER : $countones(q.light))));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !wr_ack) |=> (issue_valid && $stable(issue_mask)));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !issue_valid));
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && issue_valid));
endmodule

// File: tb/sim_wu_power_sched.sv
module sim_wu_power_sched;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         flip_mode = 1'b0;
    logic [15:0]  prefix_in = '0;
    logic         wr_ack = 1'b0;
    logic         issue_valid;
    logic [N-1:0] issue_mask;
    logic         done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wu_power_sched u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .flip_mode(flip_mode),
        .prefix_in(prefix_in), .wr_ack(wr_ack),
        .issue_valid(issue_valid), .issue_mask(issue_mask), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void split(input logic [15:0] p,
                                  output logic [N-1:0] h, output logic [N-1:0] l);
        h = '0; l = '0;
        for (int i = 0; i < N; i++) begin
            if (p[2*i +: 2] == 2'b11)      h[i] = 1'b1;
            else if (p[2*i +: 2] != 2'b00) l[i] = 1'b1;
        end
    endfunction

    function automatic logic [N-1:0] expect_group(input logic [N-1:0] h,
                                                  input logic [N-1:0] l, input bit flp);
        int left = 16;
        int ch = flp ? 8 : 16;
        int cl = flp ? 4 : 8;
        logic [N-1:0] g = '0;
        for (int i = 0; i < N; i++)
            if (h[i] && ch <= left) begin g[i] = 1'b1; left -= ch; end
        for (int i = 0; i < N; i++)
            if (l[i] && cl <= left) begin g[i] = 1'b1; left -= cl; end
        return g;
    endfunction

    task automatic run_op(input logic [15:0] pfx, input bit flp,
                          input int hold_max, output int groups);
        logic [N-1:0] h, l, em, seen, all;
        bit first;
        string rq;
        split(pfx, h, l);
        all = h | l;
        seen = '0;
        groups = 0;
        first = 1'b1;
        @(negedge clk);
        start = 1'b1; prefix_in = pfx; flip_mode = flp;
        @(negedge clk);
        start = 1'b0; prefix_in = 16'($urandom); flip_mode = ~flp;
        if (all == '0) begin
            chk(done == 1'b1, "R9", "done after start", 32'(done), 1);
            chk(issue_valid == 1'b0, "R9", "no issue", 32'(issue_valid), 0);
            @(negedge clk);
            chk(done == 1'b0, "R8", "done one cycle", 32'(done), 0);
            return;
        end
        while ((h | l) != '0) begin
            em = expect_group(h, l, flp);
            if (first) rq = "R2";
            else if (flp) rq = "R6";
            else if ((em & h) != '0) rq = "R4";
            else rq = "R5";
            first = 1'b0;
            chk(issue_valid == 1'b1, rq, "valid", 32'(issue_valid), 1);
            chk(issue_mask == em, rq, "group mask", 32'(issue_mask), 32'(em));
            seen |= issue_mask;
            for (int w = 0; w < int'($urandom_range(hold_max, 0)); w++) begin
                start = 1'($urandom);
                prefix_in = 16'($urandom);
                @(negedge clk);
                start = 1'b0;
                chk(issue_mask == em && issue_valid, "R7", "held mask", 32'(issue_mask), 32'(em));
                chk(done == 1'b0, "R10", "no restart", 32'(done), 0);
            end
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack = 1'b0;
            groups++;
            h &= ~em;
            l &= ~em;
        end
        chk(seen == all, "R3", "units written", 32'(seen), 32'(all));
        chk(done == 1'b1, "R8", "done after last ack", 32'(done), 1);
        chk(issue_valid == 1'b0, "R8", "no issue with done", 32'(issue_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", 32'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int g;
        void'($urandom(32'd4242));
        #(CLK_PERIOD * 2);
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1", "reset valid", 32'(issue_valid), 0);
        chk(issue_mask == '0, "R1", "reset mask", 32'(issue_mask), 0);
        chk(done == 1'b0, "R1", "reset done", 32'(done), 0);
        rst_n = 1'b1;

        // Example buffer: normal 4 groups, inverted 2 groups
        run_op(16'hF384, 1'b0, 2, g);
        chk(g == 4, "R5", "example group count normal", 32'(g), 4);
        run_op(16'hF384, 1'b1, 2, g);
        chk(g == 2, "R6", "example group count inverted", 32'(g), 2);

        // All zero codes
        run_op(16'h0000, 1'b0, 0, g);
        run_op(16'h0000, 1'b1, 0, g);

        // All heavy
        run_op(16'hFFFF, 1'b0, 1, g);
        chk(g == 8, "R4", "all heavy normal", 32'(g), 8);
        run_op(16'hFFFF, 1'b1, 1, g);
        chk(g == 4, "R6", "all heavy inverted", 32'(g), 4);

        // All light, mixed 01/10
        run_op(16'h6666, 1'b0, 1, g);
        chk(g == 4, "R5", "all light normal", 32'(g), 4);
        run_op(16'h9999, 1'b1, 1, g);
        chk(g == 2, "R6", "all light inverted", 32'(g), 2);

        // Odd number of light units
        run_op(16'h0015, 1'b0, 1, g);
        chk(g == 2, "R5", "odd light count", 32'(g), 2);

        // Stray ack while idle
        @(negedge clk);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        chk(issue_valid == 1'b0, "R7", "idle ack ignored valid", 32'(issue_valid), 0);
        chk(done == 1'b0, "R7", "idle ack ignored done", 32'(done), 0);
        run_op(16'hC003, 1'b0, 0, g);
        chk(g == 2, "R4", "two heavy after idle ack", 32'(g), 2);

        // Random mix
        for (int r = 0; r < 60; r++) begin
            run_op(16'($urandom), 1'($urandom), 3, g);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule